// File: doc/BRIEF.md
# Fence and Pause Execution Controller

This block sits in the memory stage of a simple in-order core and executes the instructions of the memory-ordering opcode space. Each accepted ordering instruction yields an effective predecessor set of access classes: device input, device output, memory read and memory write. The block holds a stall output high while any class in that set still has operations outstanding. The outstanding counts arrive as four plain counter inputs, one per class.

Below machine privilege, three environment-configuration bits can make device-I/O ordering also cover ordinary memory. When this promotion is active, a device-input bit in the predecessor set also orders memory reads, and a device-output bit also orders memory writes. One exact instruction word is a pause hint rather than an ordering request. It waits until every counter is clear, but never longer than `PAUSE_MAX` cycles, and when nothing is outstanding it does not wait at all.

Each instruction reports completion with a single-cycle `done` pulse. A new instruction is taken only while `stall` is low.

Top module: `fence_pause_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `stall` and `done` are both low.
- R2: A word whose bits [6:0] are not 0001111, or whose bits [14:12] are not 000, is ignored: no `done` and no `stall`.
- R3: The predecessor field is bits [27:24], with bit 3 = device input, bit 2 = device output, bit 1 = memory read and bit 0 = memory write. An ordering instruction raises `stall` in the cycle after acceptance if any counter in its effective set is nonzero. It keeps `stall` high while that holds. In the cycle after the first clock edge at which all of those counters are zero, `stall` is low and `done` is high.
- R4: An ordering instruction whose effective set has no busy counter at acceptance gives `done` in the next cycle and never raises `stall`.
- R5: Privilege `priv_lvl` = 01 (supervisor) with `virt_on` = 0 promotes when `cfg_m_fiom` is 1. Promotion sets read for device input and write for device output.
- R6: `priv_lvl` = 00 (user) with `virt_on` = 0 promotes when `cfg_m_fiom` or `cfg_s_fiom` is 1.
- R7: `priv_lvl` 00 or 01 with `virt_on` = 1 promotes when `cfg_m_fiom` or `cfg_h_fiom` is 1.
- R8: `priv_lvl` 11 (machine) and the reserved code 10 never promote, whatever `virt_on` and the configuration bits are.
- R9: The exact word 0x0100000F is the pause hint. It completes with no stall when all four counters are zero. Otherwise it stalls until all four are zero, regardless of its predecessor field.
- R10: A pause hint keeps `stall` high for at most `PAUSE_MAX` cycles and then completes with `done`.
- R11: The mode field is bits [31:28]. A value other than 0000 and 1000 makes the effective predecessor set 1111. The values 0000 and 1000 use the predecessor field as encoded.
- R12: `instr_valid` is ignored while `stall` is high. Each accepted instruction produces exactly one single-cycle `done` pulse, and `done` is never high together with `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr_word | input | 32 | Instruction word |
| priv_lvl | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| virt_on | input | 1 | Guest (virtualised) mode for user and supervisor |
| cfg_m_fiom | input | 1 | Machine-level I/O-as-memory ordering bit |
| cfg_s_fiom | input | 1 | Supervisor-level I/O-as-memory ordering bit |
| cfg_h_fiom | input | 1 | Hypervisor-level I/O-as-memory ordering bit |
| pend_dev_in | input | CNT_W | Outstanding device-input operations |
| pend_dev_out | input | CNT_W | Outstanding device-output operations |
| pend_mem_rd | input | CNT_W | Outstanding memory reads |
| pend_mem_wr | input | CNT_W | Outstanding memory writes |
| stall | output | 1 | Pipeline hold while waiting |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some rules are checked by assertions on every cycle. `done` never coincides with `stall`, and a falling `stall` always comes with `done`. An ordering wait with busy counters keeps stalling, and a pause at its cap releases on the next edge. Machine mode leaves the predecessor set unchanged, and the pause word always decodes as an ordering instruction. Only the bench scenarios can show the rest: the promotion truth table across every mode, configuration, predecessor value and busy class, the exact pause length under a never-clearing counter, the treatment of unusual mode-field values, and the fact that ignored words and inputs during a stall leave no trace.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FENCE, ST_PAUSE} fpc_state_e;

  localparam int          NUM_CLASS  = 4;
  localparam logic [6:0]  OPC_ORDER  = 7'b0001111;
  localparam logic [2:0]  F3_ORDER   = 3'b000;
  localparam logic [31:0] PAUSE_WORD = 32'h0100000F;
  localparam logic [3:0]  FM_PLAIN   = 4'b0000;
  localparam logic [3:0]  FM_TSO     = 4'b1000;
  localparam logic [3:0]  SET_ALL    = 4'b1111;

  localparam logic [1:0]  PRV_U = 2'b00;
  localparam logic [1:0]  PRV_S = 2'b01;
  localparam logic [1:0]  PRV_M = 2'b11;

  // class bit positions inside a predecessor set
  localparam int CL_IN  = 3;
  localparam int CL_OUT = 2;
  localparam int CL_RD  = 1;
  localparam int CL_WR  = 0;
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
(
  input  logic [31:0] word,
  output logic        is_order,
  output logic        is_pause,
  output logic [3:0]  pred_raw
);
  logic [3:0] fm;

  assign fm       = word[31:28];
  assign is_order = (word[6:0] == OPC_ORDER) && (word[14:12] == F3_ORDER);
  assign is_pause = (word == PAUSE_WORD);
  // unusual mode-field values are widened to the full set (R11)
  assign pred_raw = ((fm == FM_PLAIN) || (fm == FM_TSO)) ? word[27:24] : SET_ALL;

  always_comb begin
    if (is_pause) begin
      assert_pause_in_space_R9: assert (is_order && pred_raw == 4'b0001);
    end
  end
endmodule

// File: rtl/fpc_promote.sv
module fpc_promote
  import fpc_pkg::*;
(
  input  logic [3:0] pred_in,
  input  logic [1:0] priv_lvl,
  input  logic       virt_on,
  input  logic       cfg_m_fiom,
  input  logic       cfg_s_fiom,
  input  logic       cfg_h_fiom,
  output logic [3:0] pred_out
);
  logic promote_en;

  always_comb begin
    promote_en = 1'b0;
    if (priv_lvl == PRV_S && !virt_on)                      promote_en = cfg_m_fiom;                 // R5
    else if (priv_lvl == PRV_U && !virt_on)                 promote_en = cfg_m_fiom | cfg_s_fiom;    // R6
    else if ((priv_lvl == PRV_U || priv_lvl == PRV_S) && virt_on)
                                                            promote_en = cfg_m_fiom | cfg_h_fiom;    // R7
  end

  always_comb begin
    pred_out = pred_in;
    if (promote_en) begin
      pred_out[CL_RD] = pred_in[CL_RD] | pred_in[CL_IN];
      pred_out[CL_WR] = pred_in[CL_WR] | pred_in[CL_OUT];
    end
  end

  always_comb begin
    if (priv_lvl == PRV_M || priv_lvl == 2'b10) begin
      assert_machine_no_promote_R8: assert (pred_out == pred_in);
    end
  end
endmodule

// File: rtl/fpc_busy.sv
module fpc_busy
  import fpc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [NUM_CLASS-1:0][CNT_W-1:0] cnt,
  input  logic [NUM_CLASS-1:0]            mask,
  output logic                            masked_busy,
  output logic                            any_busy
);
  logic [NUM_CLASS-1:0] nz;

  for (genvar i = 0; i < NUM_CLASS; i++) begin : g_class
    assign nz[i] = |cnt[i];
  end

  assign masked_busy = |(nz & mask);
  assign any_busy    = |nz;
endmodule

// File: rtl/fence_pause_ctrl.sv
module fence_pause_ctrl
  import fpc_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int PAUSE_MAX = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [31:0]      instr_word,
  input  logic [1:0]       priv_lvl,
  input  logic             virt_on,
  input  logic             cfg_m_fiom,
  input  logic             cfg_s_fiom,
  input  logic             cfg_h_fiom,
  input  logic [CNT_W-1:0] pend_dev_in,
  input  logic [CNT_W-1:0] pend_dev_out,
  input  logic [CNT_W-1:0] pend_mem_rd,
  input  logic [CNT_W-1:0] pend_mem_wr,
  output logic             stall,
  output logic             done
);
  localparam int PW = $clog2(PAUSE_MAX + 1);
  localparam logic [PW-1:0] CAP = PW'(PAUSE_MAX);

  fpc_state_e                     st;
  logic [3:0]                     held_mask;
  logic [PW-1:0]                  pause_cnt;
  logic                           is_order, is_pause;
  logic [3:0]                     pred_raw, pred_eff, mask_sel;
  logic                           masked_busy, any_busy;
  logic [NUM_CLASS-1:0][CNT_W-1:0] cnt_vec;

  assign cnt_vec[CL_IN]  = pend_dev_in;
  assign cnt_vec[CL_OUT] = pend_dev_out;
  assign cnt_vec[CL_RD]  = pend_mem_rd;
  assign cnt_vec[CL_WR]  = pend_mem_wr;

  fpc_decode u_dec (
    .word(instr_word), .is_order(is_order), .is_pause(is_pause), .pred_raw(pred_raw)
  );

  fpc_promote u_prom (
    .pred_in(pred_raw), .priv_lvl(priv_lvl), .virt_on(virt_on),
    .cfg_m_fiom(cfg_m_fiom), .cfg_s_fiom(cfg_s_fiom), .cfg_h_fiom(cfg_h_fiom),
    .pred_out(pred_eff)
  );

  assign mask_sel = (st == ST_IDLE) ? pred_eff : held_mask;

  fpc_busy #(.CNT_W(CNT_W)) u_busy (
    .cnt(cnt_vec), .mask(mask_sel), .masked_busy(masked_busy), .any_busy(any_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      stall     <= 1'b0;
      done      <= 1'b0;
      held_mask <= '0;
      pause_cnt <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (instr_valid && is_order) begin
            if (is_pause) begin
              if (any_busy) begin
                st        <= ST_PAUSE;
                stall     <= 1'b1;
                pause_cnt <= PW'(1);
              end else begin
                done <= 1'b1;
              end
            end else begin
              held_mask <= pred_eff;
              if (masked_busy) begin
                st    <= ST_FENCE;
                stall <= 1'b1;
              end else begin
                done <= 1'b1;
              end
            end
          end
        end
        ST_FENCE: begin
          if (!masked_busy) begin
            st    <= ST_IDLE;
            stall <= 1'b0;
            done  <= 1'b1;
          end
        end
        ST_PAUSE: begin
          if (!any_busy || pause_cnt >= CAP) begin
            st    <= ST_IDLE;
            stall <= 1'b0;
            done  <= 1'b1;
          end else begin
            pause_cnt <= pause_cnt + PW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_no_done_in_stall_R12: assert property (@(posedge clk) disable iff (rst)
    !(stall && done));

  assert_release_gives_done_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> done);

  assert_fence_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FENCE && masked_busy) |=> stall);

  assert_pause_cap_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PAUSE && pause_cnt >= CAP) |=> (!stall && done));
endmodule

// File: tb/tb_fence_pause_ctrl.sv
module tb_fence_pause_ctrl;
  localparam int CNT_W     = 4;
  localparam int PAUSE_MAX = 32;

  logic             clk = 1'b0;
  logic             rst;
  logic             instr_valid;
  logic [31:0]      instr_word;
  logic [1:0]       priv_lvl;
  logic             virt_on, cfg_m_fiom, cfg_s_fiom, cfg_h_fiom;
  logic [CNT_W-1:0] pend_dev_in, pend_dev_out, pend_mem_rd, pend_mem_wr;
  logic             stall, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fence_pause_ctrl #(.CNT_W(CNT_W), .PAUSE_MAX(PAUSE_MAX)) dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .priv_lvl(priv_lvl), .virt_on(virt_on), .cfg_m_fiom(cfg_m_fiom),
    .cfg_s_fiom(cfg_s_fiom), .cfg_h_fiom(cfg_h_fiom),
    .pend_dev_in(pend_dev_in), .pend_dev_out(pend_dev_out),
    .pend_mem_rd(pend_mem_rd), .pend_mem_wr(pend_mem_wr),
    .stall(stall), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [3:0] fm, input logic [3:0] p,
                                          input logic [3:0] s);
    return {fm, p, s, 5'd0, 3'b000, 5'd0, 7'b0001111};
  endfunction

  function automatic logic [3:0] exp_mask(input logic [3:0] p, input int lvl,
                                          input int v, input logic [2:0] cfg);
    bit en;
    if (lvl == 1 && v == 0)                  en = cfg[0];
    else if (lvl == 0 && v == 0)             en = cfg[0] | cfg[1];
    else if ((lvl == 0 || lvl == 1) && v)    en = cfg[0] | cfg[2];
    else                                     en = 1'b0;
    return en ? (p | {2'b00, p[3], p[2]}) : p;
  endfunction

  function automatic string mode_tag(input int lvl, input int v);
    if (lvl == 1 && v == 0) return "R5";
    if (lvl == 0 && v == 0) return "R6";
    if (lvl <= 1)           return "R7";
    return "R8";
  endfunction

  task automatic set_cnt(input int k, input logic [CNT_W-1:0] val);
    pend_dev_in  = (k == 3) ? val : '0;
    pend_dev_out = (k == 2) ? val : '0;
    pend_mem_rd  = (k == 1) ? val : '0;
    pend_mem_wr  = (k == 0) ? val : '0;
  endtask

  // drives at a falling edge, accepted at the next rising edge, returns at the falling edge after it
  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; instr_valid = 1'b0; instr_word = '0;
    priv_lvl = 2'b11; virt_on = 0; cfg_m_fiom = 0; cfg_s_fiom = 0; cfg_h_fiom = 0;
    set_cnt(-1, '0);
    repeat (3) @(negedge clk);
    check(!stall && !done, "R1 reset outputs", {stall, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!stall && !done, "R1 after reset", {stall, done}, 0);

    // R2: words outside the ordering space
    set_cnt(0, 4'd3);
    issue(32'h00000033);
    check(!stall && !done, "R2 other opcode", {stall, done}, 0);
    issue(mk_word(4'h0, 4'hF, 4'hF) | 32'h0000_1000);
    check(!stall && !done, "R2 funct3 001", {stall, done}, 0);
    set_cnt(-1, '0);

    // R3..R8: sweep over mode, configuration, predecessor set and busy class
    for (int lvl = 0; lvl < 4; lvl++) begin
      for (int v = 0; v < 2; v++) begin
        for (int cfg = 0; cfg < 8; cfg++) begin
          for (int p = 0; p < 16; p++) begin
            for (int k = 0; k < 4; k++) begin
              logic [3:0] m;
              string t;
              m = exp_mask(4'(p), lvl, v, 3'(cfg));
              t = (m[k] != p[k]) ? mode_tag(lvl, v) : (m[k] ? "R3" : "R4");
              priv_lvl = 2'(lvl); virt_on = v[0];
              cfg_m_fiom = cfg[0]; cfg_s_fiom = cfg[1]; cfg_h_fiom = cfg[2];
              set_cnt(k, 4'd5);
              issue(mk_word(4'h0, 4'(p), 4'b0011));
              if (m[k]) begin
                check(stall && !done, t, {stall, done}, 2);
                @(negedge clk);
                check(stall && !done, {t, " hold"}, {stall, done}, 2);
                set_cnt(-1, '0);
                @(negedge clk);
                check(!stall && done, {t, " release"}, {stall, done}, 1);
              end else begin
                check(!stall && done, t, {stall, done}, 1);
              end
              set_cnt(-1, '0);
              @(negedge clk);
              check(!done && !stall, "R12 single pulse", {stall, done}, 0);
            end
          end
        end
      end
    end

    priv_lvl = 2'b11; virt_on = 0; cfg_m_fiom = 1; cfg_s_fiom = 1; cfg_h_fiom = 1;

    // R9: pause with nothing outstanding
    set_cnt(-1, '0);
    issue(32'h0100000F);
    check(!stall && done, "R9 pause idle", {stall, done}, 1);

    // R9: pause waits on a device-input count even though its set is write-only
    set_cnt(3, 4'd2);
    issue(32'h0100000F);
    check(stall && !done, "R9 pause busy", {stall, done}, 2);
    repeat (3) @(negedge clk);
    set_cnt(-1, '0);
    @(negedge clk);
    check(!stall && done, "R9 pause drained", {stall, done}, 1);

    // R10: pause capped with a counter that never clears
    set_cnt(1, 4'd1);
    begin
      int n;
      n = 0;
      issue(32'h0100000F);
      while (stall && n < 200) begin
        n++;
        @(negedge clk);
      end
      check(n == PAUSE_MAX, "R10 pause length", n, PAUSE_MAX);
      check(done, "R10 pause done", done, 1);
    end
    set_cnt(-1, '0);
    @(negedge clk);

    // R9: near-pause word (nonzero destination) is an ordinary write ordering
    set_cnt(0, 4'd1);
    issue(32'h0100008F);
    repeat (PAUSE_MAX + 8) @(negedge clk);
    check(stall && !done, "R9 near-pause not capped", {stall, done}, 2);
    set_cnt(-1, '0);
    @(negedge clk);
    check(!stall && done, "R3 near-pause release", {stall, done}, 1);

    // R11: unusual mode field widens to the full set
    set_cnt(1, 4'd4);
    issue(mk_word(4'b0100, 4'h0, 4'h0));
    check(stall, "R11 widened set", stall, 1);
    set_cnt(-1, '0);
    @(negedge clk);
    check(done, "R11 widened release", done, 1);
    set_cnt(3, 4'd4);
    issue(mk_word(4'b1000, 4'b0011, 4'b0011));
    check(!stall && done, "R11 mode 1000 uses field", {stall, done}, 1);
    set_cnt(-1, '0);
    @(negedge clk);

    // R12: valid during stall is ignored
    set_cnt(0, 4'd2);
    issue(mk_word(4'h0, 4'h1, 4'h3));
    check(stall, "R12 stalled", stall, 1);
    instr_valid = 1'b1; instr_word = 32'h0100000F;
    @(negedge clk);
    instr_valid = 1'b0;
    set_cnt(-1, '0);
    @(negedge clk);
    check(!stall && done, "R12 release", {stall, done}, 1);
    @(negedge clk);
    check(!stall && !done, "R12 no extra completion", {stall, done}, 0);
    @(negedge clk);
    check(!stall && !done, "R12 still quiet", {stall, done}, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule